// File: doc/BRIEF.md
# Smart-Card Contact Power Sequencer

This block controls when the contacts of a contact smart card are powered and when they are released. A host asks for a card session by pulling an active-LOW session command LOW. The block then raises the card supply converter, waits for the supply ramp, enables the I/O repeaters, starts the card clock, and finally lets the card reset line follow the host's reset request. Every milestone is an exact multiple of a timing unit of `UNIT_CYC` clock cycles, which is 64 by default.

A session ends when the host raises the session command, when the card is pulled out, when the supply alarm fires or when a fault is reported. The contacts are then released in reverse order, one unit apart. After power-on reset and after any supply alarm, a hold-off window blocks new sessions. A single active-LOW status line reports card presence while the session command is idle. During a session request it goes LOW to report a refused request or an abnormal shutdown.

The host can hold its reset request HIGH when it starts a session. The card clock then waits until the host lowers that request, so the host knows exactly how many clock pulses the card has seen before reset is released.

Top module: `ccs_sequencer`

## Requirements
- R1: A card is present when `det_hi` is 1 or `det_lo_n` is 0. While `sess_n` is 1, `stat_n` equals this presence value, combinationally.
- R2: After reset all contact enables are 0. A session is accepted at a clock edge where all of the following hold: the block is idle, `sess_n` is 0, `sess_n` was sampled 1 at the previous edge while idle, a card is present, `fault` is 0 and the hold-off has expired. `pwr_en` is 1 from that edge on. This edge is t1, and t is the count of edges since t1.
- R3: `vcc_up` rises when t reaches 3*UNIT_CYC/2 (96).
- R4: `io_en` rises when t reaches 4*UNIT_CYC (256). If `host_rst` was 0 at t1, `clk_en` rises at that same point.
- R5: If `host_rst` was 1 at t1, `clk_en` stays 0 until the first edge after 4*UNIT_CYC at which `host_rst` is sampled 0. If that never happens, `clk_en` is forced to 1 at 7*UNIT_CYC.
- R6: `crst` is 0 before t reaches 7*UNIT_CYC (448). From then on `crst` equals `host_rst` combinationally, and `host_rst` no longer affects `clk_en`.
- R7: Any of `sess_n`=1, card absent, `alarm`=1 or `fault`=1 during a session starts shutdown at the next edge, which is d=0. At d=0 `crst` drops to 0. `clk_en` drops at d=UNIT_CYC, `io_en` at d=2*UNIT_CYC, and `vcc_up` and `pwr_en` at d=3*UNIT_CYC.
- R8: Session requests are refused for HOLD_UNITS*UNIT_CYC cycles after reset, and for the same time after `alarm` was last 1.
- R9: A refused request (no card, fault, or hold-off) leaves all enables at 0 and drives `stat_n` to 0 while `sess_n` stays 0. After a refusal or a shutdown, `sess_n` must be seen at 1 while idle before a new session can be accepted.
- R10: A shutdown caused by card removal, alarm or fault drives `stat_n` to 0 while `sess_n` remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-LOW reset |
| sess_n | input | 1 | Session command from host, active LOW |
| host_rst | input | 1 | Card reset request from host, active HIGH |
| det_hi | input | 1 | Presence switch, active HIGH |
| det_lo_n | input | 1 | Presence switch, active LOW |
| alarm | input | 1 | Supply-drop alarm |
| fault | input | 1 | Overload or over-temperature fault |
| pwr_en | output | 1 | Card supply converter enable |
| vcc_up | output | 1 | Card supply ramp complete, supply applied |
| io_en | output | 1 | I/O repeater enable |
| clk_en | output | 1 | Card clock gate enable |
| crst | output | 1 | Card reset contact |
| stat_n | output | 1 | Status/interrupt to host, active LOW |

## Verification
An off-by-one in the milestone timer moves the rising edge of `vcc_up`, `io_en`, `clk_en` or `crst` by a cycle. Because every output is compared cycle by cycle across a whole session, the error shows at the first milestone it touches. A corrupted shutdown snapshot or a wrong step count shows within three units of the trigger, as a contact released out of order or held too long. Errors in the re-arm flag, the fault flag or the hold-off counter show at the next session request, as a start that should not happen (or a missing one) or a wrong `stat_n` level.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ON   = 2'd1,
      ST_OFF  = 2'd2
   } ccs_state_e;

   typedef struct packed {
      logic vcc;
      logic io;
      logic clk;
   } ccs_snap_t;
endpackage

// File: rtl/ccs_timer.sv
module ccs_timer #(
   parameter int LIMIT = 448,
   localparam int W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("ccs_timer: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (run && cnt != TOP)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ccs_holdoff.sv
module ccs_holdoff #(
   parameter int HOLD_CYC = 25600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm,
   output logic ready
);
   generate
      if (HOLD_CYC < 0) begin : g_bad
         $error("ccs_holdoff: HOLD_CYC must not be negative");
      end else if (HOLD_CYC == 0) begin : g_none
         assign ready = !alarm;
      end else begin : g_cnt
         localparam int HW = $clog2(HOLD_CYC + 1);
         localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);
         logic [HW-1:0] remain;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               remain <= LOAD;
            else if (alarm)
               remain <= LOAD;
            else if (remain != '0)
               remain <= remain - 1'b1;
         end

         assign ready = (remain == '0) && !alarm;
      end
   endgenerate
endmodule

// File: rtl/ccs_detect.sv
module ccs_detect #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_hi,
   input  logic raw_lo_n,
   output logic present
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad
         $error("ccs_detect: SYNC_STAGES must be 0 to 3");
      end else if (SYNC_STAGES == 0) begin : g_direct
         assign present = raw_hi | ~raw_lo_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] s_hi;
         logic [SYNC_STAGES-1:0] s_lo;
         logic [SYNC_STAGES:0]   c_hi;
         logic [SYNC_STAGES:0]   c_lo;

         assign c_hi = {s_hi, raw_hi};
         assign c_lo = {s_lo, raw_lo_n};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_hi <= '0;
               s_lo <= '1;
            end else begin
               s_hi <= c_hi[SYNC_STAGES-1:0];
               s_lo <= c_lo[SYNC_STAGES-1:0];
            end
         end

         assign present = s_hi[SYNC_STAGES-1] | ~s_lo[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ccs_sequencer.sv
module ccs_sequencer
   import ccs_pkg::*;
#(
   parameter int UNIT_CYC    = 64,
   parameter int HOLD_UNITS  = 400,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sess_n,
   input  logic host_rst,
   input  logic det_hi,
   input  logic det_lo_n,
   input  logic alarm,
   input  logic fault,
   output logic pwr_en,
   output logic vcc_up,
   output logic io_en,
   output logic clk_en,
   output logic crst,
   output logic stat_n
);
   localparam int RAMP_CYC = (3 * UNIT_CYC) / 2;
   localparam int IO_CYC   = 4 * UNIT_CYC;
   localparam int RST_CYC  = 7 * UNIT_CYC;
   localparam int OFF_LEN  = 3 * UNIT_CYC;
   localparam int HOLD_CYC = HOLD_UNITS * UNIT_CYC;
   localparam int TW       = $clog2(RST_CYC + 1);

   localparam logic [TW-1:0] T_RAMP  = TW'(RAMP_CYC);
   localparam logic [TW-1:0] T_IO    = TW'(IO_CYC);
   localparam logic [TW-1:0] T_RST   = TW'(RST_CYC);
   localparam logic [TW-1:0] T_CLKOF = TW'(UNIT_CYC);
   localparam logic [TW-1:0] T_IOOF  = TW'(2 * UNIT_CYC);
   localparam logic [TW-1:0] T_LAST  = TW'(OFF_LEN - 1);

   generate
      if (UNIT_CYC < 2 || (UNIT_CYC % 2) != 0) begin : g_bad_unit
         $error("ccs_sequencer: UNIT_CYC must be even and at least 2");
      end
      if (HOLD_UNITS < 0) begin : g_bad_hold
         $error("ccs_sequencer: HOLD_UNITS must not be negative");
      end
   endgenerate

   ccs_state_e    st;
   ccs_snap_t     snap;
   logic [TW-1:0] t;
   logic          present;
   logic          hold_ready;
   logic          armed;
   logic          clk_hold;
   logic          flt;
   logic          accept;
   logic          reject;
   logic          stop;
   logic          abnormal;

   ccs_detect #(.SYNC_STAGES(SYNC_STAGES)) i_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_hi   (det_hi),
      .raw_lo_n (det_lo_n),
      .present  (present)
   );

   ccs_holdoff #(.HOLD_CYC(HOLD_CYC)) i_holdoff (
      .clk   (clk),
      .rst_n (rst_n),
      .alarm (alarm),
      .ready (hold_ready)
   );

   ccs_timer #(.LIMIT(RST_CYC)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept | stop),
      .run   (st != ST_IDLE),
      .cnt   (t)
   );

   // request decoding
   always_comb begin
      accept   = (st == ST_IDLE) && !sess_n && armed && present
                 && !fault && hold_ready;
      reject   = (st == ST_IDLE) && !sess_n && armed && !accept;
      stop     = (st == ST_ON) && (sess_n || !present || alarm || fault);
      abnormal = stop && (!present || alarm || fault);
   end

   // phase state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= ST_IDLE;
      else begin
         unique case (st)
            ST_IDLE: if (accept) st <= ST_ON;
            ST_ON:   if (stop) st <= ST_OFF;
            ST_OFF:  if (t == T_LAST) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // re-arm: the command must be seen idle before a new start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (st != ST_IDLE)
         armed <= 1'b0;
      else
         armed <= sess_n;
   end

   // clock hold requested by the host at session start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         clk_hold <= 1'b0;
      else if (accept)
         clk_hold <= host_rst;
      else if (st == ST_ON && !host_rst)
         clk_hold <= 1'b0;
   end

   // contacts live at the moment shutdown begins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         snap <= '0;
      else if (stop)
         snap <= '{vcc: vcc_up, io: io_en, clk: clk_en};
   end

   // refusal / abnormal shutdown flag for the status line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flt <= 1'b0;
      else if (reject || abnormal)
         flt <= 1'b1;
      else if (sess_n)
         flt <= 1'b0;
   end

   // contact enables
   always_comb begin
      pwr_en = 1'b0;
      vcc_up = 1'b0;
      io_en  = 1'b0;
      clk_en = 1'b0;
      crst   = 1'b0;
      unique case (st)
         ST_ON: begin
            pwr_en = 1'b1;
            vcc_up = (t >= T_RAMP);
            io_en  = (t >= T_IO);
            clk_en = (t >= T_IO) && (!clk_hold || t >= T_RST);
            crst   = (t >= T_RST) && host_rst;
         end
         ST_OFF: begin
            pwr_en = 1'b1;
            vcc_up = snap.vcc;
            io_en  = snap.io && (t < T_IOOF);
            clk_en = snap.clk && (t < T_CLKOF);
         end
         default: ;
      endcase
   end

   assign stat_n = sess_n ? present : !flt;
endmodule

// File: rtl/ccs_chk.sv
module ccs_chk (
   input logic clk,
   input logic rst_n,
   input logic sess_n,
   input logic host_rst,
   input logic hold_ready,
   input logic pwr_en,
   input logic vcc_up,
   input logic io_en,
   input logic clk_en,
   input logic crst
);
   a_r7_clk_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> io_en);

   a_r7_io_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
      io_en |-> vcc_up);

   a_r3_vcc_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_up |-> pwr_en);

   a_r6_crst_follows: assert property (@(posedge clk) disable iff (!rst_n)
      crst |-> (clk_en && host_rst));

   a_r2_start_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> $past(!sess_n));

   a_r8_no_start_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_ready |=> !$rose(pwr_en));

   a_r7_supply_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> $past(!io_en && !clk_en));
endmodule

bind ccs_sequencer ccs_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sess_n     (sess_n),
   .host_rst   (host_rst),
   .hold_ready (hold_ready),
   .pwr_en     (pwr_en),
   .vcc_up     (vcc_up),
   .io_en      (io_en),
   .clk_en     (clk_en),
   .crst       (crst)
);

// File: tb/test_ccs_sequencer.sv
module test_ccs_sequencer;
   localparam int U    = 64;
   localparam int HU   = 400;
   localparam int HOLD = U * HU;

   logic clk = 1'b0;
   logic rst_n, sess_n, host_rst, det_hi, det_lo_n, alarm, fault;
   logic pwr_en, vcc_up, io_en, clk_en, crst, stat_n;
   int   checks = 0;
   int   failures = 0;
   int   cyc = 0;

   always #5 clk = ~clk;

   ccs_sequencer #(.UNIT_CYC(U), .HOLD_UNITS(HU), .SYNC_STAGES(0)) i_ccs_sequencer (
      .clk(clk), .rst_n(rst_n), .sess_n(sess_n), .host_rst(host_rst),
      .det_hi(det_hi), .det_lo_n(det_lo_n), .alarm(alarm), .fault(fault),
      .pwr_en(pwr_en), .vcc_up(vcc_up), .io_en(io_en), .clk_en(clk_en),
      .crst(crst), .stat_n(stat_n)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // session start driven just before; m counts negedges, edge count t = m-1
   task automatic run_on(input bit hold, input int rel_m, input int last_m);
      for (int m = 1; m <= last_m; m++) begin
         int t;
         bit hexp;
         @(negedge clk);
         t = m - 1;
         hexp = hold && !(rel_m > 0 && m > rel_m);
         chk(pwr_en, 1'b1, "R2 pwr_en");
         chk(vcc_up, t >= 3 * U / 2, "R3 vcc_up");
         chk(io_en, t >= 4 * U, "R4 io_en");
         chk(clk_en, (t >= 4 * U) && (!hexp || t >= 7 * U), "R5 clk_en");
         chk(crst, (t >= 7 * U) && host_rst, "R6 crst");
         if (m == rel_m) host_rst = 1'b0;
      end
   endtask

   // trigger driven just before; d = m-1
   task automatic run_off(input int alarm_m);
      for (int m = 1; m <= 3 * U + 4; m++) begin
         @(negedge clk);
         chk(crst, 1'b0, "R7 crst off");
         chk(clk_en, m <= U, "R7 clk_en off");
         chk(io_en, m <= 2 * U, "R7 io_en off");
         chk(vcc_up, m <= 3 * U, "R7 vcc_up off");
         chk(pwr_en, m <= 3 * U, "R7 pwr_en off");
         if (m == alarm_m) alarm = 1'b0;
      end
   endtask

   initial begin
      while (1) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      rst_n = 0; sess_n = 1; host_rst = 0; det_hi = 0; det_lo_n = 1;
      alarm = 0; fault = 0;
      step(4); rst_n = 1; step(1);
      chk(pwr_en, 0, "R2 reset pwr_en"); chk(clk_en, 0, "R2 reset clk_en");
      chk(io_en, 0, "R2 reset io_en"); chk(crst, 0, "R2 reset crst");
      chk(stat_n, 0, "R1 no card");
      det_hi = 1; step(1); chk(stat_n, 1, "R1 det_hi");
      det_hi = 0; det_lo_n = 0; step(1); chk(stat_n, 1, "R1 det_lo_n");
      det_lo_n = 1; step(1); chk(stat_n, 0, "R1 removed");
      det_lo_n = 0; step(1000);
      // request inside power-on hold-off
      sess_n = 0; step(5);
      chk(pwr_en, 0, "R8 hold-off after reset"); chk(stat_n, 0, "R9 refusal status");
      sess_n = 1; step(1); chk(stat_n, 1, "R1 present idle");
      step(HOLD);
      // session A: host reset low at start, then reset released by host
      sess_n = 0;
      run_on(0, 0, 460);
      host_rst = 1; step(1);
      chk(crst, 1, "R6 crst copies"); chk(clk_en, 1, "R6 clk independent");
      host_rst = 0; step(1); chk(crst, 0, "R6 crst copies low");
      host_rst = 1; step(1);
      sess_n = 1;
      run_off(0);
      chk(stat_n, 1, "R1 after normal stop");
      host_rst = 0; step(2);
      // session B: clock held by host until m=300, ended by card removal
      host_rst = 1; sess_n = 0;
      run_on(1, 300, 460);
      det_lo_n = 1;
      run_off(0);
      chk(stat_n, 0, "R10 removal status");
      det_lo_n = 0; step(20);
      chk(pwr_en, 0, "R9 needs re-arm");
      sess_n = 1; step(1); chk(stat_n, 1, "R1 re-arm");
      // session C: host reset held to 7T, ended by fault
      host_rst = 1; sess_n = 0;
      run_on(1, 0, 452);
      fault = 1;
      run_off(0);
      chk(stat_n, 0, "R10 fault status");
      host_rst = 0; sess_n = 1; step(2);
      sess_n = 0; step(5);
      chk(pwr_en, 0, "R9 fault refusal"); chk(stat_n, 0, "R9 fault refusal status");
      fault = 0; sess_n = 1; step(2);
      // session D: alarm shutdown, then alarm hold-off
      sess_n = 0;
      run_on(0, 0, 300);
      alarm = 1;
      run_off(3);
      chk(stat_n, 0, "R10 alarm status");
      sess_n = 1; step(1000);
      sess_n = 0; step(5);
      chk(pwr_en, 0, "R8 hold-off after alarm");
      sess_n = 1; step(HOLD);
      sess_n = 0; step(1);
      chk(pwr_en, 1, "R8 start after hold-off");
      sess_n = 1; step(3 * U + 5);
      chk(pwr_en, 0, "R7 final stop");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule